// File: doc/BRIEF.md
# DDR Write Data Burst Sequencer

This block converts accepted write commands into a cycle-accurate stream of write data for a double-data-rate interface. It delivers two beats per clock: one for the rising half and one for the falling half. It also produces a strobe-enable window for the strobe driver and a one-clock-ahead data request toward the user write buffer. Each command carries its own burst length, either 4 beats (two data clocks) or 8 beats (four data clocks). The first data clock falls a programmable write latency after the command.

Pending bursts live in a shift register of slots, one slot per future clock, so a command that arrives while earlier bursts are still in flight is merged into the schedule and not lost. Back-to-back commands at the burst's own pitch give an unbroken stream. A command flagged as an interrupt, arriving exactly two clocks after an 8-beat command, cuts that earlier burst after its first four beats. The new burst's beats then follow without a gap. Burst start and end markers travel alongside the data so that downstream logic sees where each burst, truncated or not, begins and ends.

Top module: `ddr_wr_burst_seq`

## Requirements
- R1: A synchronous active-low reset clears every pending burst. While reset is applied, and in the clock after it, `dq_valid`, `dqs_en`, `dreq`, `burst_first` and `burst_last` are low and `dq_rise`/`dq_fall` are zero. A command accepted before the reset produces no data afterwards.
- R2: A write command sampled in clock k makes clock k+WL the first data clock of its burst. WL is the `wl` input, and a `wl` value of 0 or 1 is treated as 2.
- R3: With `wr_len8`=1 the burst occupies four consecutive data clocks. With `wr_len8`=0 it occupies two. Each data clock carries one beat on `dq_rise` and one on `dq_fall`.
- R4: 4-beat commands issued every 2 clocks, or 8-beat commands issued every 4 clocks, give `dq_valid` high with no idle clock between bursts.
- R5: A command with `wr_intr`=1 sampled exactly 2 clocks after an 8-beat command truncates that earlier burst to its first two data clocks. The new burst's data clocks follow directly after them.
- R6: `wr_intr` has no effect when the command two clocks earlier was a 4-beat command, or when the previous command was issued at any other distance. The schedule is then the same as with `wr_intr`=0.
- R7: `dreq` is high in exactly the clocks that precede a data clock. The `usr_rise`/`usr_fall` values sampled at the end of such a clock appear on `dq_rise`/`dq_fall` in the following clock.
- R8: `dqs_en` is high in every data clock and in the clock before any data clock (preamble), and low otherwise.
- R9: In every clock that is not a data clock, `dq_rise` and `dq_fall` are zero.
- R10: `burst_first` is high on the first data clock of each burst. `burst_last` is high on its last data clock, and for a truncated burst that is its second data clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_cmd | input | 1 | Write command accepted this clock |
| wr_len8 | input | 1 | 1: 8-beat burst, 0: 4-beat burst |
| wr_intr | input | 1 | This command interrupts the 8-beat burst issued two clocks earlier |
| wl | input | WL_W | Write latency in clocks (values below 2 act as 2) |
| usr_rise | input | DATA_W | Rising-half beat from the user buffer, sampled when `dreq` is high |
| usr_fall | input | DATA_W | Falling-half beat from the user buffer, sampled when `dreq` is high |
| dreq | output | 1 | Request for two beats; the next clock is a data clock |
| dq_rise | output | DATA_W | Rising-half data beat |
| dq_fall | output | DATA_W | Falling-half data beat |
| dq_valid | output | 1 | Current clock is a data clock |
| dqs_en | output | 1 | Strobe enable, including a one-clock preamble |
| burst_first | output | 1 | First data clock of a burst |
| burst_last | output | 1 | Last data clock of a burst |

## Verification
In a seamless or interrupted stream, the data request for the next burst's first clock falls in the same cycle as the last data clock of the burst before it. In the interrupt case, the same schedule update also moves the old burst's end marker and inserts the new burst on top of slots the old burst still occupies. The bench provokes this with commands at 2- and 4-clock spacing and with interrupts at the smallest latency of 2 as well as at larger ones. Every clock it compares `dreq`, `dqs_en`, `dq_valid`, the markers and both beats against a queue of expected beats. The driver builds that queue from the requirements, including the trimming of the interrupted burst.

// File: rtl/ddr_wrseq_pkg.sv
// Package: shared slot type and burst-size helper for the write sequencer.
package ddr_wrseq_pkg;

    // One scheduled clock: carries data, and may start or end a burst.
    typedef struct packed {
        logic data;
        logic first;
        logic last;
    } slot_t;

    // Number of data clocks of a burst minus one (4 beats -> 1, 8 beats -> 3).
    function automatic logic [2:0] burst_span(input logic len8);
        return len8 ? 3'd3 : 3'd1;
    endfunction

endpackage

// File: rtl/ddr_wrseq_intr_detect.sv
// Module: ddr_wrseq_intr_detect
// Decides whether an incoming command legally truncates an earlier burst.
// It remembers, for two clocks, whether an 8-beat command was accepted.
// Assumes the command checker upstream never issues a command in between.
module ddr_wrseq_intr_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_cmd,
    input  logic wr_len8,
    input  logic wr_intr,
    output logic honor
);

    logic bl8_d1;
    logic bl8_d2;

    // Two-stage history of 8-beat commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bl8_d1 <= 1'b0;
            bl8_d2 <= 1'b0;
        end else begin
            bl8_d1 <= wr_cmd & wr_len8;
            bl8_d2 <= bl8_d1;
        end
    end

    // The interrupt counts only two clocks after an 8-beat command.
    always_comb begin
        honor = wr_cmd & wr_intr & bl8_d2;
    end

endmodule

// File: rtl/ddr_wrseq_slot_sched.sv
// Module: ddr_wrseq_slot_sched
// Schedule of future clocks, one slot per clock, shifting toward slot 0 each
// cycle. Slot i after an edge describes the clock i cycles after the current
// one. A new command marks data slots from offset WL-1. A truncation clears
// the old end marker and sets it on the old burst's second data clock.
// Assumes wl_eff >= 2 and that DEPTH exceeds the largest offset used.
module ddr_wrseq_slot_sched #(
    parameter int WL_W  = 4,
    parameter int DEPTH = (1 << WL_W) + 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ins,
    input  logic                       len8,
    input  logic                       honor,
    input  logic [WL_W-1:0]            wl_eff,
    output ddr_wrseq_pkg::slot_t       slot_now,
    output ddr_wrseq_pkg::slot_t       slot_next
);
    import ddr_wrseq_pkg::*;

    localparam int OFF_W = $clog2(DEPTH);

    logic [OFF_W-1:0] start_off;
    logic [OFF_W-1:0] end_off;
    logic [OFF_W-1:0] clr_off;
    logic [OFF_W-1:0] cut_off;
    slot_t [DEPTH-1:0] slots;

    // Offsets where a new burst and a truncation land after this edge.
    always_comb begin
        start_off = OFF_W'(wl_eff) - OFF_W'(1);
        end_off   = start_off + OFF_W'(burst_span(len8));
        clr_off   = OFF_W'(wl_eff);
        cut_off   = OFF_W'(wl_eff) - OFF_W'(2);
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        localparam logic [OFF_W-1:0] IDX = OFF_W'(i);
        slot_t upper;
        slot_t nxt;
        slot_t q;

        if (i == DEPTH - 1) begin : g_top
            assign upper = '0;
        end else begin : g_mid
            assign upper = slots[i+1];
        end

        // Next content: shifted slot, merged with the new burst and truncation.
        always_comb begin
            nxt.data  = upper.data | (ins && (IDX >= start_off) && (IDX <= end_off));
            nxt.first = upper.first | (ins && (IDX == start_off));
            nxt.last  = (upper.last & ~(honor && (IDX == clr_off)))
                      | (ins && (IDX == end_off))
                      | (honor && (IDX == cut_off));
        end

        // Slot register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else begin
                q <= nxt;
            end
        end

        assign slots[i] = q;
    end

    assign slot_now  = slots[0];
    assign slot_next = slots[1];

endmodule

// File: rtl/ddr_wrseq_beat_out.sv
// Module: ddr_wrseq_beat_out
// Output stage for the two beats of a data clock. When a request is pending
// it captures the user's pair at the edge and holds it for the data clock;
// otherwise it drives zeros. Assumes the user answers a request in the same clock.
module ddr_wrseq_beat_out #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] usr_rise,
    input  logic [DATA_W-1:0] usr_fall,
    output logic [DATA_W-1:0] dq_rise,
    output logic [DATA_W-1:0] dq_fall
);

    // Beat registers: load on request, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_rise <= '0;
            dq_fall <= '0;
        end else if (take) begin
            dq_rise <= usr_rise;
            dq_fall <= usr_fall;
        end else begin
            dq_rise <= '0;
            dq_fall <= '0;
        end
    end

endmodule

// File: rtl/ddr_wr_burst_seq.sv
// Module: ddr_wr_burst_seq
// Top of the write data burst sequencer. It clamps the latency, finds legal
// truncations, keeps the schedule of future data clocks and drives the beats.
// The strobe window and the data request are taken straight from the schedule.
// Assumes commands arrive already checked for legal spacing.
module ddr_wr_burst_seq #(
    parameter int DATA_W = 16,
    parameter int WL_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic              wr_len8,
    input  logic              wr_intr,
    input  logic [WL_W-1:0]   wl,
    input  logic [DATA_W-1:0] usr_rise,
    input  logic [DATA_W-1:0] usr_fall,
    output logic              dreq,
    output logic [DATA_W-1:0] dq_rise,
    output logic [DATA_W-1:0] dq_fall,
    output logic              dq_valid,
    output logic              dqs_en,
    output logic              burst_first,
    output logic              burst_last
);
    import ddr_wrseq_pkg::*;

    localparam int DEPTH = (1 << WL_W) + 3;

    logic [WL_W-1:0] wl_eff;
    logic            honor;
    slot_t           slot_now;
    slot_t           slot_next;

    // Latency below two leaves no room for the request clock.
    always_comb begin
        wl_eff = (wl < WL_W'(2)) ? WL_W'(2) : wl;
    end

    ddr_wrseq_intr_detect u_intr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_cmd  (wr_cmd),
        .wr_len8 (wr_len8),
        .wr_intr (wr_intr),
        .honor   (honor)
    );

    ddr_wrseq_slot_sched #(
        .WL_W  (WL_W),
        .DEPTH (DEPTH)
    ) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins       (wr_cmd),
        .len8      (wr_len8),
        .honor     (honor),
        .wl_eff    (wl_eff),
        .slot_now  (slot_now),
        .slot_next (slot_next)
    );

    ddr_wrseq_beat_out #(
        .DATA_W (DATA_W)
    ) u_beats (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (slot_next.data),
        .usr_rise (usr_rise),
        .usr_fall (usr_fall),
        .dq_rise  (dq_rise),
        .dq_fall  (dq_fall)
    );

    // Status outputs decoded from the two nearest slots.
    always_comb begin
        dreq        = slot_next.data;
        dq_valid    = slot_now.data;
        dqs_en      = slot_now.data | slot_next.data;
        burst_first = slot_now.first;
        burst_last  = slot_now.last;
    end

endmodule

// File: rtl/ddr_wr_burst_seq_chk.sv
// Module: ddr_wr_burst_seq_chk
// Port-level properties of the sequencer, attached to the top by bind.
module ddr_wr_burst_seq_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dreq,
    input logic [DATA_W-1:0] dq_rise,
    input logic [DATA_W-1:0] dq_fall,
    input logic              dq_valid,
    input logic              dqs_en,
    input logic              burst_first,
    input logic              burst_last
);

    assert_strobe_on_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dq_valid |-> dqs_en);

    assert_preamble_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_valid) |-> $past(dqs_en));

    assert_no_data_without_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dqs_en |=> !dq_valid);

    assert_request_leads_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dreq |=> dq_valid);

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_valid |-> (dq_rise == '0 && dq_fall == '0));

    assert_marks_in_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_first || burst_last) |-> dq_valid);

endmodule

bind ddr_wr_burst_seq ddr_wr_burst_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dreq        (dreq),
    .dq_rise     (dq_rise),
    .dq_fall     (dq_fall),
    .dq_valid    (dq_valid),
    .dqs_en      (dqs_en),
    .burst_first (burst_first),
    .burst_last  (burst_last)
);

// File: tb/ddr_wr_burst_seq_bench.sv
// Scoreboard bench: the driver queues expected beats, the monitor compares them.
module ddr_wr_burst_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;
    localparam int WL_W       = 4;
    localparam int HIST       = 4096;

    typedef struct {
        int cyc;
        bit first;
        bit last;
    } beat_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_cmd = 1'b0;
    logic              wr_len8 = 1'b0;
    logic              wr_intr = 1'b0;
    logic [WL_W-1:0]   wl = WL_W'(4);
    logic [DATA_W-1:0] usr_rise;
    logic [DATA_W-1:0] usr_fall;
    logic              dreq;
    logic [DATA_W-1:0] dq_rise;
    logic [DATA_W-1:0] dq_fall;
    logic              dq_valid;
    logic              dqs_en;
    logic              burst_first;
    logic              burst_last;

    int    cyc = 0;
    int    n_checks = 0;
    int    n_errors = 0;
    int    last_cyc = -100;
    bit    last_len8 = 1'b0;
    bit    exp_busy [HIST];
    beat_t exp_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DATA_W-1:0] pat_r(input int c);
        return DATA_W'(c * 37 + 5);
    endfunction

    function automatic logic [DATA_W-1:0] pat_f(input int c);
        return DATA_W'(c * 91 + 11);
    endfunction

    assign usr_rise = pat_r(cyc);
    assign usr_fall = pat_f(cyc);

    ddr_wr_burst_seq #(.DATA_W(DATA_W), .WL_W(WL_W)) u_ddr_wr_burst_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_cmd      (wr_cmd),
        .wr_len8     (wr_len8),
        .wr_intr     (wr_intr),
        .wl          (wl),
        .usr_rise    (usr_rise),
        .usr_fall    (usr_fall),
        .dreq        (dreq),
        .dq_rise     (dq_rise),
        .dq_fall     (dq_fall),
        .dq_valid    (dq_valid),
        .dqs_en      (dqs_en),
        .burst_first (burst_first),
        .burst_last  (burst_last)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
        end
    endtask

    // Driver: issue one command this clock and queue its expected beats (R2, R3, R5, R6).
    task automatic issue(input bit len8, input bit intr);
        int k;
        int we;
        int n;
        bit hon;
        k   = cyc;
        we  = (int'(wl) < 2) ? 2 : int'(wl);
        n   = len8 ? 4 : 2;
        hon = intr && (last_cyc == k - 2) && last_len8;
        if (hon) begin
            void'(exp_q.pop_back());
            void'(exp_q.pop_back());
            exp_q[exp_q.size() - 1].last = 1'b1;
        end
        for (int j = 0; j < n; j++) begin
            beat_t b;
            b.cyc   = k + we + j;
            b.first = (j == 0);
            b.last  = (j == n - 1);
            exp_q.push_back(b);
            exp_busy[k + we + j] = 1'b1;
        end
        last_cyc  = k;
        last_len8 = len8;
        wr_cmd  = 1'b1;
        wr_len8 = len8;
        wr_intr = intr;
        @(negedge clk);
        wr_cmd  = 1'b0;
        wr_len8 = 1'b0;
        wr_intr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reset for one clock mid-run; everything scheduled after it is dropped (R1).
    task automatic pulse_reset();
        int m;
        m = cyc;
        exp_q.delete();
        for (int i = m + 1; i < HIST; i++) exp_busy[i] = 1'b0;
        last_cyc = -100;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: per clock, compare the outputs with the expected schedule.
    always @(negedge clk) begin
        if (cyc >= 1 && cyc < HIST - 1) begin
            bit ev;
            ev = exp_busy[cyc];
            chk("R2/R3/R4", "dq_valid", int'(dq_valid), int'(ev));
            chk("R7", "dreq", int'(dreq), int'(exp_busy[cyc + 1]));
            chk("R8", "dqs_en", int'(dqs_en), int'(ev | exp_busy[cyc + 1]));
            if (ev) begin
                if (exp_q.size() == 0) begin
                    chk("R5", "queue empty on data clock", 1, 0);
                end else begin
                    beat_t b;
                    b = exp_q.pop_front();
                    chk("R5", "beat cycle", cyc, b.cyc);
                    chk("R10", "burst_first", int'(burst_first), int'(b.first));
                    chk("R10", "burst_last", int'(burst_last), int'(b.last));
                    chk("R7", "dq_rise", int'(dq_rise), int'(pat_r(cyc - 1)));
                    chk("R7", "dq_fall", int'(dq_fall), int'(pat_f(cyc - 1)));
                end
            end else begin
                chk("R9", "dq_rise idle", int'(dq_rise), 0);
                chk("R9", "dq_fall idle", int'(dq_fall), 0);
                chk("R10", "markers idle", int'({burst_first, burst_last}), 0);
            end
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < HIST; i++) exp_busy[i] = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        chk("R1", "reset outputs", int'({dreq, dq_valid, dqs_en, burst_first, burst_last}), 0);
        chk("R1", "reset data", int'(dq_rise | dq_fall), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R2 R3: single 4-beat burst with preamble
        wl = WL_W'(4);
        issue(1'b0, 1'b0); idle(8);
        // R4: 4-beat commands every 2 clocks
        issue(1'b0, 1'b0); idle(1); issue(1'b0, 1'b0); idle(1); issue(1'b0, 1'b0); idle(10);
        // R4: 8-beat commands every 4 clocks
        issue(1'b1, 1'b0); idle(3); issue(1'b1, 1'b0); idle(12);
        // R5: 8-beat burst cut by an 8-beat interrupt
        issue(1'b1, 1'b0); idle(1); issue(1'b1, 1'b1); idle(12);
        // R5: 8-beat burst cut by a 4-beat interrupt
        issue(1'b1, 1'b0); idle(1); issue(1'b0, 1'b1); idle(12);
        // R6: interrupt after a 4-beat command is ignored
        issue(1'b0, 1'b0); idle(1); issue(1'b0, 1'b1); idle(10);
        // R6: interrupt four clocks after an 8-beat command is ignored
        issue(1'b1, 1'b0); idle(3); issue(1'b1, 1'b1); idle(12);
        // R8: one idle clock between bursts keeps the strobe window open
        issue(1'b0, 1'b0); idle(2); issue(1'b0, 1'b0); idle(10);
        // R5: interrupt at the smallest latency
        wl = WL_W'(2);
        issue(1'b1, 1'b0); idle(1); issue(1'b1, 1'b1); idle(10);
        // R2: larger latency, seamless pair
        wl = WL_W'(9);
        issue(1'b0, 1'b0); idle(1); issue(1'b0, 1'b0); idle(16);
        // R2: largest latency
        wl = WL_W'(15);
        issue(1'b1, 1'b0); idle(22);
        // R2: latency 0 and 1 act as 2
        wl = WL_W'(0);
        issue(1'b0, 1'b0); idle(6);
        wl = WL_W'(1);
        issue(1'b1, 1'b0); idle(8);
        // R1: reset drops a burst already accepted
        wl = WL_W'(4);
        issue(1'b1, 1'b0); pulse_reset(); idle(12);
        // R1: sequencer works normally after the mid-run reset
        issue(1'b0, 1'b0); idle(8);

        chk("R1", "queue drained", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule